// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is one port of general-purpose pins for a small microcontroller bus. Each pin is controlled by two stored bits, a direction bit and a data bit. A third path lets the bus read the pad level. The bus writes and reads these through three addresses, and the write and read strobes are shared by every pin of the port. For each pin, the block drives an output value, an output enable and a pull-up enable toward the pad cell.

A pin whose direction bit is set drives its data bit onto the pad. A pin whose direction bit is clear is an input. On an input pin, the data bit turns on the pull-up, unless the chip-wide pull-up disable input is high. Pad levels are carried into the clock domain by a two-stage synchroniser before the bus can read them. While the sleep input is high, the synchroniser sees a constant low, so floating pads cannot toggle internal logic. Writing ones to the pin address flips the matching data bits, which gives software a single-write toggle.

Reset clears both stored registers asynchronously. All pins are therefore released and all pull-ups are off even when no clock is running.

Top module: `gpio_port`

## Requirements
- R1: While `rst` is high, `pad_oe` and `pad_pu` are all zero and the direction and data registers read back as zero. The effect is asynchronous and needs no clock edge.
- R2: A write (`wr_en`=1) with `addr`=0 loads `wdata` into the direction register at the next clock edge. `pad_oe` equals the direction register.
- R3: `pad_out[i]` equals data bit i when direction bit i is 1, and is 0 otherwise.
- R4: `pad_pu[i]` is 1 exactly when direction bit i is 0, data bit i is 1 and `pud_all` is 0.
- R5: While `pud_all` is 1, every bit of `pad_pu` is 0, whatever the register contents.
- R6: A write with `addr`=1 loads `wdata` into the data register. With `rd_en`=1, `rdata` returns the direction register for `addr`=0 and the data register for `addr`=1, within the same cycle.
- R7: A write with `addr`=2 inverts each data register bit whose `wdata` bit is 1 and leaves the others unchanged. The direction register is not affected.
- R8: With `rd_en`=1 and `addr`=2, `rdata` returns the synchronised pad levels. A pad change is captured at the first clock edge after it and is visible after the second edge.
- R9: While `sleep` is 1, the synchroniser input is forced low. After two clock edges with `sleep` high, a pin read returns all zeros.
- R10: A write with `addr`=3 changes no register. A read with `addr`=3, or any read with `rd_en`=0, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst | input | 1 | Asynchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 2 | Register select: 0 direction, 1 data, 2 pin, 3 unmapped |
| wdata | input | PINS | Bus write data |
| rdata | output | PINS | Bus read data (combinational) |
| pud_all | input | 1 | Chip-wide pull-up disable |
| sleep | input | 1 | Gates the synchroniser input low |
| pad_in | input | PINS | Raw pad levels |
| pad_out | output | PINS | Value driven toward the pads |
| pad_oe | output | PINS | Output enable per pin |
| pad_pu | output | PINS | Pull-up enable per pin |

## Verification
A corrupted direction or data bit is visible at the pad outputs in the same cycle: `pad_oe`, `pad_out` and `pad_pu` are combinational in those registers. It also appears on the next register read, so the bench compares all three pad vectors and the read-back after every random bus operation. A synchroniser fault shows up as a pin read that is one edge early, one edge late, or not zero under sleep. Directed cases read exactly at the first and second edge after a pad change to expose this.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        SEL_DIR  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_PIN  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_e sel;
    } bus_req_t;

    typedef struct packed {
        logic drive;
        logic oe;
        logic pu;
    } pad_ctl_t;

    function automatic pad_ctl_t pad_control(input logic dir_bit,
                                             input logic data_bit,
                                             input logic pud);
        pad_ctl_t c;
        c.oe    = dir_bit;
        c.drive = dir_bit & data_bit;
        c.pu    = ~dir_bit & data_bit & ~pud;
        return c;
    endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  bus_req_t        req,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] dir_q,
    output logic [PINS-1:0] data_q
);

    logic wr_dir, wr_data, wr_pin;

    always_comb begin
        wr_dir  = req.wr && (req.sel == SEL_DIR);
        wr_data = req.wr && (req.sel == SEL_DATA);
        wr_pin  = req.wr && (req.sel == SEL_PIN);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            dir_q <= '0;
        end else if (wr_dir) begin
            dir_q <= wdata;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            data_q <= '0;
        end else if (wr_data) begin
            data_q <= wdata;
        end else if (wr_pin) begin
            data_q <= data_q ^ wdata;
        end
    end

    // R7: pin-address write flips selected data bits, direction untouched
    a_r7_pin_toggle: assert property (@(posedge clk) disable iff (rst)
        wr_pin |=> (data_q == ($past(data_q) ^ $past(wdata))) && $stable(dir_q));

    // R10: unmapped write leaves both registers unchanged
    a_r10_no_write: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_NONE) |=> $stable(dir_q) && $stable(data_q));

    // R2: direction register only moves on a direction write
    a_r2_dir_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_dir |=> $stable(dir_q));

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sleep,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] pin_sync
);

    logic [PINS-1:0] gated;
    logic [PINS-1:0] stage1;

    always_comb gated = sleep ? '0 : pad_in;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            stage1   <= '0;
            pin_sync <= '0;
        end else begin
            stage1   <= gated;
            pin_sync <= stage1;
        end
    end

    // R9: two edges of sleep leave the synchronised value at zero
    a_r9_sleep_zero: assert property (@(posedge clk) disable iff (rst)
        (sleep && $past(sleep)) |=> (pin_sync == '0));

    // R8: synchronised value is the first stage one edge later
    a_r8_two_stage: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pin_sync == $past(stage1)));

endmodule

// File: rtl/gpio_port_pads.sv
module gpio_port_pads
    import gpio_port_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] dir_q,
    input  logic [PINS-1:0] data_q,
    input  logic            pud_all,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] pad_pu
);

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        pad_ctl_t ctl;
        always_comb begin
            ctl        = pad_control(dir_q[i], data_q[i], pud_all);
            pad_out[i] = ctl.drive;
            pad_oe[i]  = ctl.oe;
            pad_pu[i]  = ctl.pu;
        end
    end

    // R5: global disable wins over every pull-up
    a_r5_pud_off: assert property (@(posedge clk) disable iff (rst)
        pud_all |-> (pad_pu == '0));

    // R4: a pull-up is never active on a driving pin
    a_r4_pu_input_only: assert property (@(posedge clk) disable iff (rst)
        (pad_pu & pad_oe) == '0);

    // R3: nothing is driven on a released pin
    a_r3_no_drive_released: assert property (@(posedge clk) disable iff (rst)
        (pad_out & ~pad_oe) == '0);

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [1:0]      addr,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] rdata,
    input  logic            pud_all,
    input  logic            sleep,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] pad_pu
);

    bus_req_t        req;
    logic [PINS-1:0] dir_q, data_q, pin_sync;

    always_comb begin
        req.wr  = wr_en;
        req.rd  = rd_en;
        req.sel = reg_sel_e'(addr);
    end

    gpio_port_regs #(.PINS(PINS)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .wdata  (wdata),
        .dir_q  (dir_q),
        .data_q (data_q)
    );

    gpio_port_sync #(.PINS(PINS)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .sleep    (sleep),
        .pad_in   (pad_in),
        .pin_sync (pin_sync)
    );

    gpio_port_pads #(.PINS(PINS)) u_pads (
        .clk     (clk),
        .rst     (rst),
        .dir_q   (dir_q),
        .data_q  (data_q),
        .pud_all (pud_all),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .pad_pu  (pad_pu)
    );

    always_comb begin
        rdata = '0;
        if (req.rd) begin
            unique case (req.sel)
                SEL_DIR:  rdata = dir_q;
                SEL_DATA: rdata = data_q;
                SEL_PIN:  rdata = pin_sync;
                default:  rdata = '0;
            endcase
        end
    end

    // R10: reads without strobe return zero
    a_r10_idle_read: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rdata == '0));

    // R1: pins released on the first edge after reset
    a_r1_released: assert property (@(posedge clk)
        $past(rst) |-> (pad_oe == '0) && (pad_pu == '0));

endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;
    localparam int PINS = 8;
    localparam int CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst, wr_en, rd_en, pud_all, sleep;
    logic [1:0]      addr;
    logic [PINS-1:0] wdata, pad_in;
    logic [PINS-1:0] rdata, pad_out, pad_oe, pad_pu;

    int checks = 0;
    int errors = 0;
    logic [PINS-1:0] m_dir, m_data;

    gpio_port #(.PINS(PINS)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pud_all(pud_all), .sleep(sleep),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [PINS-1:0] exp_out(logic [PINS-1:0] d, logic [PINS-1:0] v);
        return d & v;
    endfunction
    function automatic logic [PINS-1:0] exp_pu(logic [PINS-1:0] d, logic [PINS-1:0] v, logic p);
        return p ? '0 : (~d & v);
    endfunction

    task automatic check(string req, logic [PINS-1:0] act, logic [PINS-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] a, logic [PINS-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        case (a)
            2'd0: m_dir  = d;
            2'd1: m_data = d;
            2'd2: m_data = m_data ^ d;
            default: ;
        endcase
    endtask

    task automatic bus_read(logic [1:0] a, output logic [PINS-1:0] v);
        rd_en = 1'b1; addr = a;
        #1;
        v = rdata;
        rd_en = 1'b0;
    endtask

    task automatic check_pads(string tag);
        #1;
        check({tag, " R2 oe"}, pad_oe, m_dir);
        check({tag, " R3 out"}, pad_out, exp_out(m_dir, m_data));
        check({tag, " R4 pu"}, pad_pu, exp_pu(m_dir, m_data, pud_all));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [PINS-1:0] v;
        void'($urandom(32'h5eed_0042));
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        pud_all = 1'b0; sleep = 1'b0; pad_in = '0;
        m_dir = '0; m_data = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset oe", pad_oe, '0);
        check("R1 reset pu", pad_pu, '0);
        bus_read(2'd0, v); check("R1 reset dir", v, '0);
        bus_read(2'd1, v); check("R1 reset data", v, '0);
        @(negedge clk); rst = 1'b0;

        // R2/R6 directed
        bus_write(2'd0, 8'hF0);
        bus_write(2'd1, 8'h3C);
        check_pads("directed");
        bus_read(2'd0, v); check("R6 read dir", v, 8'hF0);
        bus_read(2'd1, v); check("R6 read data", v, 8'h3C);
        check("R4 pu pattern", pad_pu, 8'h0C);

        // R5
        @(negedge clk); pud_all = 1'b1; #1;
        check("R5 pud all off", pad_pu, '0);
        @(negedge clk); pud_all = 1'b0;

        // R7 toggle
        bus_write(2'd2, 8'h0F);
        bus_read(2'd1, v); check("R7 toggle data", v, 8'h33);
        bus_read(2'd0, v); check("R7 dir unchanged", v, 8'hF0);
        bus_write(2'd2, 8'h00);
        bus_read(2'd1, v); check("R7 zero write no change", v, 8'h33);

        // R10 unmapped
        bus_write(2'd3, 8'hAA);
        bus_read(2'd0, v); check("R10 dir kept", v, 8'hF0);
        bus_read(2'd1, v); check("R10 data kept", v, 8'h33);
        bus_read(2'd3, v); check("R10 read unmapped", v, '0);
        @(negedge clk); addr = 2'd0; rd_en = 1'b0; #1;
        check("R10 no strobe", rdata, '0);

        // R8 synchroniser latency
        @(negedge clk); pad_in = 8'hA5;
        @(posedge clk); #1;
        bus_read(2'd2, v); check("R8 one edge old", v, 8'h00);
        @(posedge clk); #1;
        bus_read(2'd2, v); check("R8 two edges new", v, 8'hA5);

        // R9 sleep gating
        @(negedge clk); sleep = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        bus_read(2'd2, v); check("R9 sleep zero", v, '0);
        @(negedge clk); sleep = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        bus_read(2'd2, v); check("R9 wake value", v, 8'hA5);

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [1:0] a;
            logic [PINS-1:0] d, p;
            a = 2'($urandom_range(0, 3));
            d = PINS'($urandom);
            p = PINS'($urandom);
            @(negedge clk);
            pud_all = 1'($urandom_range(0, 1));
            pad_in = p;
            bus_write(a, d);
            @(posedge clk); #1;
            check_pads("random");
            bus_read(2'd0, v); check("R6 random dir", v, m_dir);
            bus_read(2'd1, v); check("R6 random data", v, m_data);
            bus_read(2'd2, v); check("R8 random pin", v, p);
        end

        // R1 asynchronous reset mid-cycle
        bus_write(2'd0, 8'hFF);
        bus_write(2'd1, 8'h0F);
        @(negedge clk); #1;
        rst = 1'b1; #1;
        m_dir = '0; m_data = '0;
        check("R1 async oe", pad_oe, '0);
        check("R1 async pu", pad_pu, '0);
        check("R1 async out", pad_out, '0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule